// File: doc/BRIEF.md
# Sensor Standby Sequencer

This block takes an image-sensor readout core into a low-power standby state and brings it back out. A standby request comes from one of two places: an external pin, which passes through a two-stage synchronizer and can be masked by a configuration bit, or a control-register bit that is already in the block's clock domain. Both requests have the same effect. The first request seen while active is latched, together with a note of which source raised it. From then on the entry sequence runs to the end, even if the request goes away.

The sequence waits until the row being read out is finished. It then gates the internal clocks, disables the analog chain, forces every video output low and, unless configured otherwise, asks the PLL to power down. Standby ends only when the recorded source withdraws its request. Exit then runs a fixed order: the clocks restart, the analog chain is restored after a programmable wait, a one-cycle timing restart pulse follows after a second programmable wait, and normal operation resumes. Register contents live outside this block and are not affected by it.

All control and status pins are plain levels or single-cycle pulses. The block has no streaming interface, so no back-pressure rules apply.

Top module: `sensor_standby_ctrl`

## Requirements
- R1: With `pin_mask_i`=0, a rise of `stby_pin_i` moves `phase_o` from 0 to 1 on the third rising clock edge after the change. With `pin_mask_i`=1, the pin starts no standby.
- R2: With `reg_stby_i`=1 in the active phase, `phase_o` becomes 1 on the next rising edge.
- R3: Once the drain phase is entered, withdrawing the request does not abort the sequence. Standby is still reached.
- R4: In the drain phase (`phase_o`=1) the block waits while `row_busy_i`=1. Clocks and analog stay enabled and the video inputs pass through unchanged. The edge after `row_busy_i` is seen low moves it to standby (`phase_o`=2).
- R5: In standby, `clk_gate_en_o`=0 and `analog_en_o`=0.
- R6: In standby and in the exit phase, `lv_o`, `fv_o`, `pclk_o`, `flash_o` and `dout_o` are all 0.
- R7: Standby is released only by the source that started it. For a pin source, a register bit change has no effect. For a register source, pin activity has no effect. A pin source is released three edges after the pin falls.
- R8: The exit order is fixed. For `clk_wait_i`+1 cycles the clocks run with analog off. Then for `ana_wait_i`+1 cycles both are on. `phase_o`=3 for the whole exit.
- R9: The exit ends with `timing_restart_o` high for exactly one cycle, and the next cycle is active (`phase_o`=0).
- R10: `pll_pd_req_o` is 1 in standby when `pll_keep_i`=0. It is 0 when `pll_keep_i`=1, and it is 0 in every other phase.
- R11: `phase_o` encodes 0 active, 1 draining row, 2 standby, 3 exiting. After reset it is 0, with clocks and analog enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_pin_i | input | 1 | Asynchronous external standby request |
| pin_mask_i | input | 1 | 1 ignores the pin for new entries |
| reg_stby_i | input | 1 | Register standby request |
| pll_keep_i | input | 1 | 1 keeps the PLL powered in standby |
| clk_wait_i | input | CNT_W | Extra cycles of clock-only restart |
| ana_wait_i | input | CNT_W | Extra cycles after analog restore |
| row_busy_i | input | 1 | Row readout in progress |
| lv_i | input | 1 | Line valid from core |
| fv_i | input | 1 | Frame valid from core |
| pclk_i | input | 1 | Pixel clock from core |
| flash_i | input | 1 | Flash strobe from core |
| dout_i | input | DATA_W | Pixel data from core |
| clk_gate_en_o | output | 1 | 1 lets internal clocks run |
| analog_en_o | output | 1 | 1 enables the analog chain |
| pll_pd_req_o | output | 1 | PLL power-down request |
| timing_restart_o | output | 1 | One-cycle timing restart pulse |
| phase_o | output | 2 | Current phase |
| lv_o | output | 1 | Gated line valid |
| fv_o | output | 1 | Gated frame valid |
| pclk_o | output | 1 | Gated pixel clock |
| flash_o | output | 1 | Gated flash |
| dout_o | output | DATA_W | Gated pixel data |

## Verification
Every output is decoded from the state register, so a change is due one edge after the input that causes it. A register request reaches the drain phase after one edge. A pin change costs two more edges for the synchronizer. Exit lasts `clk_wait_i`+`ana_wait_i`+3 cycles, and the following cycle is active. The bench drives inputs on the falling edge and samples on the next falling edge, which is the first point where an edge's result is visible. It counts cycles exactly, and the exit sweep checks every cycle of every wait combination against that arithmetic.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE  = 2'd0,
    PH_DRAIN   = 2'd1,
    PH_STANDBY = 2'd2,
    PH_EXIT    = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_ACT     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_STBY    = 3'd2,
    ST_CLKUP   = 3'd3,
    ST_ANAUP   = 3'd4,
    ST_RESTART = 3'd5
  } state_t;

  function automatic phase_t phase_of(state_t s);
    case (s)
      ST_ACT:   return PH_ACTIVE;
      ST_DRAIN: return PH_DRAIN;
      ST_STBY:  return PH_STANDBY;
      default:  return PH_EXIT;
    endcase
  endfunction
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_req_i,
  input  logic             pin_mask_i,
  input  logic             reg_req_i,
  input  logic             row_busy_i,
  input  logic             pll_keep_i,
  input  logic [CNT_W-1:0] clk_wait_i,
  input  logic [CNT_W-1:0] ana_wait_i,
  output logic             clk_gate_en_o,
  output logic             analog_en_o,
  output logic             pll_pd_req_o,
  output logic             timing_restart_o,
  output logic             force_low_o,
  output logic [1:0]       phase_o
);
  state_t           st_q, st_d;
  logic             src_q, src_d;   // 1: pin started standby, 0: register
  logic [CNT_W-1:0] cnt_q;
  logic             release_w;

  assign release_w = src_q ? !pin_req_i : !reg_req_i;

  always_comb begin
    st_d  = st_q;
    src_d = src_q;
    case (st_q)
      ST_ACT: begin
        if (pin_req_i && !pin_mask_i) begin
          st_d  = ST_DRAIN;
          src_d = 1'b1;
        end else if (reg_req_i) begin
          st_d  = ST_DRAIN;
          src_d = 1'b0;
        end
      end
      ST_DRAIN:   if (!row_busy_i)      st_d = ST_STBY;
      ST_STBY:    if (release_w)        st_d = ST_CLKUP;
      ST_CLKUP:   if (cnt_q == '0)      st_d = ST_ANAUP;
      ST_ANAUP:   if (cnt_q == '0)      st_d = ST_RESTART;
      ST_RESTART:                       st_d = ST_ACT;
      default:                          st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ACT;
      src_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt_q <= '0;
    else if (st_q == ST_STBY && release_w)         cnt_q <= clk_wait_i;
    else if (st_q == ST_CLKUP && cnt_q == '0)      cnt_q <= ana_wait_i;
    else if ((st_q == ST_CLKUP || st_q == ST_ANAUP) && cnt_q != '0)
                                                   cnt_q <= cnt_q - 1'b1;
  end

  assign clk_gate_en_o    = (st_q != ST_STBY);
  assign analog_en_o      = (st_q != ST_STBY) && (st_q != ST_CLKUP);
  assign pll_pd_req_o     = (st_q == ST_STBY) && !pll_keep_i;
  assign timing_restart_o = (st_q == ST_RESTART);
  assign force_low_o      = (st_q == ST_STBY) || (st_q == ST_CLKUP) ||
                            (st_q == ST_ANAUP) || (st_q == ST_RESTART);
  assign phase_o          = phase_of(st_q);

  a_r3_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && row_busy_i) |=> st_q == ST_DRAIN);
  a_r4_gate_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gate_en_o) |-> $past(st_q) == ST_DRAIN);
  a_r7_source_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ACT) |=> $stable(src_q));
  a_r8_analog_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(analog_en_o) |-> $past(clk_gate_en_o));
  a_r8_clock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en_o) |-> !analog_en_o);
  a_r9_single_restart: assert property (@(posedge clk) disable iff (!rst_n)
    timing_restart_o |=> (st_q == ST_ACT) && !timing_restart_o);
endmodule

// File: rtl/stby_vidgate.sv
module stby_vidgate #(
  parameter int DATA_W = 10
) (
  input  logic              force_low_i,
  input  logic              lv_i,
  input  logic              fv_i,
  input  logic              pclk_i,
  input  logic              flash_i,
  input  logic [DATA_W-1:0] dout_i,
  output logic              lv_o,
  output logic              fv_o,
  output logic              pclk_o,
  output logic              flash_o,
  output logic [DATA_W-1:0] dout_o
);
  assign lv_o    = lv_i    & ~force_low_i;
  assign fv_o    = fv_i    & ~force_low_i;
  assign pclk_o  = pclk_i  & ~force_low_i;
  assign flash_o = flash_i & ~force_low_i;
  assign dout_o  = dout_i  & {DATA_W{~force_low_i}};
endmodule

// File: rtl/sensor_standby_ctrl.sv
module sensor_standby_ctrl #(
  parameter int DATA_W     = 10,
  parameter int CNT_W      = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_pin_i,
  input  logic              pin_mask_i,
  input  logic              reg_stby_i,
  input  logic              pll_keep_i,
  input  logic [CNT_W-1:0]  clk_wait_i,
  input  logic [CNT_W-1:0]  ana_wait_i,
  input  logic              row_busy_i,
  input  logic              lv_i,
  input  logic              fv_i,
  input  logic              pclk_i,
  input  logic              flash_i,
  input  logic [DATA_W-1:0] dout_i,
  output logic              clk_gate_en_o,
  output logic              analog_en_o,
  output logic              pll_pd_req_o,
  output logic              timing_restart_o,
  output logic [1:0]        phase_o,
  output logic              lv_o,
  output logic              fv_o,
  output logic              pclk_o,
  output logic              flash_o,
  output logic [DATA_W-1:0] dout_o
);
  logic pin_sync;
  logic force_low;

  stby_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (stby_pin_i),
    .q_o   (pin_sync)
  );

  stby_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .pin_req_i        (pin_sync),
    .pin_mask_i       (pin_mask_i),
    .reg_req_i        (reg_stby_i),
    .row_busy_i       (row_busy_i),
    .pll_keep_i       (pll_keep_i),
    .clk_wait_i       (clk_wait_i),
    .ana_wait_i       (ana_wait_i),
    .clk_gate_en_o    (clk_gate_en_o),
    .analog_en_o      (analog_en_o),
    .pll_pd_req_o     (pll_pd_req_o),
    .timing_restart_o (timing_restart_o),
    .force_low_o      (force_low),
    .phase_o          (phase_o)
  );

  stby_vidgate #(.DATA_W(DATA_W)) u_gate (
    .force_low_i (force_low),
    .lv_i        (lv_i),
    .fv_i        (fv_i),
    .pclk_i      (pclk_i),
    .flash_i     (flash_i),
    .dout_i      (dout_i),
    .lv_o        (lv_o),
    .fv_o        (fv_o),
    .pclk_o      (pclk_o),
    .flash_o     (flash_o),
    .dout_o      (dout_o)
  );

  a_r6_quiet_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |-> (dout_o == '0) && !lv_o && !fv_o && !pclk_o && !flash_o);
endmodule

// File: tb/sensor_standby_ctrl_test.sv
module sensor_standby_ctrl_test;
  localparam int DW = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_pin = 0, pin_mask = 0, reg_stby = 0, pll_keep = 0, row_busy = 0;
  logic [CW-1:0] clk_wait = '0, ana_wait = '0;
  logic lv = 1, fv = 1, pclk = 1, flash = 1;
  logic [DW-1:0] din = '1;
  logic gate_en, ana_en, pll_pd, trst, lv_o, fv_o, pclk_o, flash_o;
  logic [1:0] phase;
  logic [DW-1:0] dout;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sensor_standby_ctrl #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .stby_pin_i(stby_pin), .pin_mask_i(pin_mask),
    .reg_stby_i(reg_stby), .pll_keep_i(pll_keep), .clk_wait_i(clk_wait),
    .ana_wait_i(ana_wait), .row_busy_i(row_busy), .lv_i(lv), .fv_i(fv),
    .pclk_i(pclk), .flash_i(flash), .dout_i(din), .clk_gate_en_o(gate_en),
    .analog_en_o(ana_en), .pll_pd_req_o(pll_pd), .timing_restart_o(trst),
    .phase_o(phase), .lv_o(lv_o), .fv_o(fv_o), .pclk_o(pclk_o),
    .flash_o(flash_o), .dout_o(dout));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // {phase, gate, analog, restart, pll, all-video-or}
  function automatic int snap();
    return {phase, gate_en, ana_en, trst, pll_pd, (|dout) | lv_o | fv_o | pclk_o | flash_o};
  endfunction

  function automatic int mk(int ph, bit g, bit a, bit r, bit p, bit v);
    return (ph << 5) | (g << 4) | (a << 3) | (r << 2) | (p << 1) | v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic wait_active();
    for (int i = 0; i < 40 && phase != 2'd0; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11", "reset state", snap(), mk(0, 1, 1, 0, 0, 1));

    // R1 mask blocks pin
    pin_mask = 1; stby_pin = 1;
    for (int i = 0; i < 6; i++) tick();
    chk("R1", "masked pin", snap(), mk(0, 1, 1, 0, 0, 1));
    stby_pin = 0;
    for (int i = 0; i < 3; i++) tick();
    pin_mask = 0;

    // R2/R3/R4 register entry, drain, no abort
    row_busy = 1; reg_stby = 1;
    tick();
    chk("R2", "drain after one edge", phase, 1);
    reg_stby = 0;
    for (int i = 0; i < 4; i++) tick();
    chk("R4", "drain waits, passes video", snap(), mk(1, 1, 1, 0, 0, 1));
    chk("R4", "data pass", dout, (1 << DW) - 1);
    row_busy = 0;
    tick();
    chk("R3", "standby despite withdrawn request", phase, 2);
    chk("R5", "gated in standby", {gate_en, ana_en}, 0);
    tick();
    chk("R8", "exit begins", phase, 3);
    wait_active();

    // R1 pin latency, R7 reg cannot release pin source
    stby_pin = 1;
    tick(); chk("R1", "pin edge 1", phase, 0);
    tick(); chk("R1", "pin edge 2", phase, 0);
    tick(); chk("R1", "pin edge 3 drain", phase, 1);
    tick(); chk("R5", "pin standby", phase, 2);
    reg_stby = 1; tick(); tick();
    reg_stby = 0; tick(); tick();
    chk("R7", "reg ignored for pin source", phase, 2);
    chk("R6", "video low in standby", snap() & 1, 0);
    stby_pin = 0;
    tick(); chk("R7", "pin release edge 1", phase, 2);
    tick(); chk("R7", "pin release edge 2", phase, 2);
    tick(); chk("R7", "pin release edge 3", phase, 3);
    wait_active();

    // R7 pin cannot release register source
    reg_stby = 1; tick(); tick();
    chk("R2", "reg standby", phase, 2);
    stby_pin = 1; for (int i = 0; i < 4; i++) tick();
    stby_pin = 0; for (int i = 0; i < 4; i++) tick();
    chk("R7", "pin ignored for reg source", phase, 2);
    reg_stby = 0; tick();
    chk("R7", "reg release", phase, 3);
    wait_active();

    // R8/R9/R10/R6 sweep of waits and PLL option
    for (int k = 0; k < 2; k++) begin
      for (int cw = 0; cw < 4; cw++) begin
        for (int aw = 0; aw < 4; aw++) begin
          pll_keep = k[0];
          clk_wait = CW'(cw); ana_wait = CW'(aw);
          reg_stby = 1; tick(); tick();
          chk("R10", "standby pll request", snap(), mk(2, 0, 0, 0, !k[0], 0));
          reg_stby = 0;
          for (int i = 1; i <= cw + aw + 4; i++) begin
            tick();
            if (i <= cw + 1)
              chk("R8", "clock-only step", snap(), mk(3, 1, 0, 0, 0, 0));
            else if (i <= cw + aw + 2)
              chk("R8", "analog step", snap(), mk(3, 1, 1, 0, 0, 0));
            else if (i == cw + aw + 3)
              chk("R9", "restart pulse", snap(), mk(3, 1, 1, 1, 0, 0));
            else
              chk("R9", "active after restart", snap(), mk(0, 1, 1, 0, 0, 1));
          end
        end
      end
    end
    finish_run();
  end
endmodule